// File: doc/BRIEF.md
# Hit Timestamp Channel

This block timestamps hits for a single detector channel. A discriminator output arrives with no relation to the fast clock. The block passes it through a flip-flop synchronizer and picks out each 0-to-1 transition. It then tags the transition with the current value of a free-running coarse counter. Each tag is stored in a small local FIFO. A downstream collector drains the FIFO through a first-word-fall-through read port: data is valid whenever the empty flag is low, and each read strobe moves the port to the next entry.

All channels of a board share one counter-clear pulse. This pulse gives every channel the same time origin. It also clears the sticky overflow flag, which the channel raises when it has to drop a hit because its FIFO is full. The time resolution is one fast-clock period. Edges that arrive closer together than the synchronizer can separate are merged into one record.

Top module: `tdc_hit_channel`

## Requirements
- R1: After reset, `fifo_empty` is 1 and `overflow` is 0.
- R2: Suppose `cnt_clear` was last sampled high at clock edge c, and `hit_async` rises before clock edge n and stays high over that edge. The stored timestamp is then (n + 1 - c) mod 2^STAMP_W.
- R3: Such a hit becomes visible on the read port (`fifo_empty` low) right after edge n+3. It is not visible after edge n+2.
- R4: A level that stays high for many cycles produces exactly one record.
- R5: The coarse counter steps by one on every edge and wraps from 2^STAMP_W-1 to 0. The default 8-bit stamp therefore wraps 255 to 0.
- R6: An edge that samples `cnt_clear` high loads the counter with 0, whatever the increment would have given. The following edge gives 1.
- R7: Records leave in arrival order. `fifo_data` shows the oldest record while `fifo_empty` is 0. A high `rd_en` at an edge moves the port to the next record.
- R8: A hit that reaches a full FIFO (DEPTH entries) is discarded and sets `overflow`. The flag stays at 1 until an edge samples `cnt_clear` high. A clear in the same cycle as a drop wins.
- R9: `rd_en` while the FIFO is empty has no effect on later contents or order.
- R10: A read and a write at the same edge keep the occupancy unchanged and lose no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_async | input | 1 | Raw discriminator level, asynchronous to clk |
| cnt_clear | input | 1 | Synchronous pulse that zeroes the counter and clears overflow |
| rd_en | input | 1 | Read strobe from the collector |
| fifo_empty | output | 1 | High when no record is stored |
| fifo_data | output | STAMP_W | Oldest stored timestamp, valid while fifo_empty is low |
| overflow | output | 1 | Sticky flag for a dropped hit |

## Verification
The collector can read the oldest record at the same edge that the hit pipeline writes a new one. The bench provokes this overlap by first letting the FIFO hold three records while draining is held off. It then switches draining on and fires fresh hits at once, so the reads and the writes land on shared edges. The scoreboard judges the result: every stamp must come out once, in order, and with its computed value. A checker property also requires the occupancy to stay the same across any such edge.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  // Next value of a wrapping counter; a clear request wins over the step.
  function automatic int unsigned tick_next(int unsigned cur, logic clr, int unsigned modulus);
    if (clr) return 0;
    return (cur + 1) % modulus;
  endfunction

  // Next index of a ring of the given depth.
  function automatic int unsigned ring_next(int unsigned ptr, int unsigned depth);
    return (ptr + 1 == depth) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/tdc_sync_edge.sv
module tdc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/tdc_coarse_counter.sv
module tdc_coarse_counter
  import tdc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] value
);
  localparam int unsigned MODULUS = 32'(1) << W;

  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else        value <= W'(tick_next(32'(value), clr, MODULUS));
  end
endmodule

// File: rtl/tdc_hit_fifo.sv
module tdc_hit_fifo
  import tdc_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  input  logic             ovf_clr,
  output logic [W-1:0]     rd_data,
  output logic             empty,
  output logic             full,
  output logic             overflow,
  output logic             wr_fire,
  output logic             rd_fire,
  output logic [$clog2(DEPTH+1)-1:0] occupancy
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          drop;

  assign empty   = (occupancy == '0);
  assign full    = (occupancy == OCC_W'(DEPTH));
  assign wr_fire = wr_req & ~full;
  assign rd_fire = rd_en & ~empty;
  assign drop    = wr_req & full;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      occupancy <= '0;
      overflow  <= 1'b0;
    end else begin
      if (wr_fire) wr_ptr <= AW'(ring_next(32'(wr_ptr), DEPTH));
      if (rd_fire) rd_ptr <= AW'(ring_next(32'(rd_ptr), DEPTH));
      case ({wr_fire, rd_fire})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
      if (ovf_clr)   overflow <= 1'b0;
      else if (drop) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/tdc_hit_channel.sv
module tdc_hit_channel #(
  parameter int STAMP_W     = 8,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_async,
  input  logic               cnt_clear,
  input  logic               rd_en,
  output logic               fifo_empty,
  output logic [STAMP_W-1:0] fifo_data,
  output logic               overflow
);
  localparam int OCC_W = $clog2(DEPTH+1);

  // Named internal events, observed by the bound checker.
  logic               rise_flag;
  logic [STAMP_W-1:0] coarse_cnt;
  logic               wr_req;
  logic [STAMP_W-1:0] wr_stamp;
  logic               wr_fire;
  logic               rd_fire;
  logic               fifo_full;
  logic [OCC_W-1:0]   occupancy;

  tdc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (hit_async),
    .rise (rise_flag)
  );

  tdc_coarse_counter #(.W(STAMP_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clear),
    .value(coarse_cnt)
  );

  // Capture stage between edge detection and FIFO write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_req   <= 1'b0;
      wr_stamp <= '0;
    end else begin
      wr_req   <= rise_flag;
      wr_stamp <= coarse_cnt;
    end
  end

  tdc_hit_fifo #(.W(STAMP_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .wr_data  (wr_stamp),
    .rd_en    (rd_en),
    .ovf_clr  (cnt_clear),
    .rd_data  (fifo_data),
    .empty    (fifo_empty),
    .full     (fifo_full),
    .overflow (overflow),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire),
    .occupancy(occupancy)
  );
endmodule

// File: rtl/tdc_hit_channel_chk.sv
module tdc_hit_channel_chk #(
  parameter int STAMP_W = 8,
  parameter int OCC_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cnt_clear,
  input logic               rd_en,
  input logic               fifo_empty,
  input logic               overflow,
  input logic               wr_req,
  input logic               wr_fire,
  input logic               rd_fire,
  input logic               fifo_full,
  input logic [OCC_W-1:0]   occupancy,
  input logic [STAMP_W-1:0] coarse_cnt
);
  AST_WRITE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !fifo_full) |=> !fifo_empty);                                   // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> coarse_cnt == STAMP_W'($past(coarse_cnt) + 1'b1));          // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> coarse_cnt == '0);                                           // R6
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && fifo_full && !cnt_clear) |=> overflow);                         // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !cnt_clear) |=> overflow);                                    // R8
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && rd_en && !wr_req) |=> fifo_empty);                          // R9
  AST_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_fire) |=> $stable(occupancy));                              // R10
endmodule

bind tdc_hit_channel tdc_hit_channel_chk #(
  .STAMP_W(STAMP_W), .OCC_W($clog2(DEPTH+1))
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_clear (cnt_clear),
  .rd_en     (rd_en),
  .fifo_empty(fifo_empty),
  .overflow  (overflow),
  .wr_req    (wr_req),
  .wr_fire   (wr_fire),
  .rd_fire   (rd_fire),
  .fifo_full (fifo_full),
  .occupancy (occupancy),
  .coarse_cnt(coarse_cnt)
);

// File: tb/tdc_hit_channel_tb.sv
`timescale 1ns/1ps
module tdc_hit_channel_tb;
  localparam int W     = 8;
  localparam int DEPTH = 16;
  localparam int MOD   = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hit_async = 1'b0;
  logic         cnt_clear = 1'b0;
  logic         rd_en;
  logic         fifo_empty;
  logic [W-1:0] fifo_data;
  logic         overflow;

  logic rd_mon = 1'b0;
  logic rd_force = 1'b0;
  assign rd_en = rd_mon | rd_force;

  int checks = 0;
  int failures = 0;
  int edge_n = 0;
  int clr_edge = 0;
  int held = 0;
  bit drain = 1'b0;
  bit done = 1'b0;
  int exp_q[$];

  tdc_hit_channel #(.STAMP_W(W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .hit_async(hit_async), .cnt_clear(cnt_clear),
    .rd_en(rd_en), .fifo_empty(fifo_empty), .fifo_data(fifo_data), .overflow(overflow)
  );

  always #5 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int stamp_for(int n);
    return (((n + 1 - clr_edge) % MOD) + MOD) % MOD;
  endfunction

  // Scoreboard monitor: pops and compares while draining is on.
  always @(negedge clk) begin
    if (drain && !fifo_empty && rst_n) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected record", int'(fifo_data), -1);
      else begin
        automatic int e = exp_q.pop_front();
        chk(int'(fifo_data) == e, "R2 R7 R10 stamp order", int'(fifo_data), e);
      end
      rd_mon = 1'b1;
    end else rd_mon = 1'b0;
  end

  task automatic pulse_clear();
    cnt_clear = 1'b1;
    clr_edge = edge_n + 1;
    @(negedge clk);
    cnt_clear = 1'b0;
  endtask

  // Driver: raises the hit at a negedge and predicts the record.
  task automatic fire_hit(int hi, int lo);
    automatic int n = edge_n + 1;
    hit_async = 1'b1;
    if (!drain && held >= DEPTH) begin
      // expected to be dropped
    end else begin
      exp_q.push_back(stamp_for(n));
      if (!drain) held++;
    end
    repeat (hi) @(negedge clk);
    hit_async = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic take_direct(string tag);
    chk(!fifo_empty, {tag, " record present"}, int'(fifo_empty), 0);
    if (exp_q.size() > 0) begin
      automatic int e = exp_q.pop_front();
      chk(int'(fifo_data) == e, {tag, " stamp"}, int'(fifo_data), e);
    end
    rd_force = 1'b1;
    @(negedge clk);
    rd_force = 1'b0;
    if (held > 0) held--;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(fifo_empty == 1'b1, "R1 empty after reset", int'(fifo_empty), 1);
    chk(overflow == 1'b0, "R1 overflow after reset", int'(overflow), 0);
    rst_n = 1'b1;
    @(negedge clk);
    pulse_clear();

    // R3 latency and R2 value, hand-sampled
    begin
      automatic int n = edge_n + 1;
      hit_async = 1'b1;
      exp_q.push_back(stamp_for(n));
      held++;
      repeat (3) @(negedge clk);
      chk(fifo_empty == 1'b1, "R3 not visible after n+2", int'(fifo_empty), 1);
      hit_async = 1'b0;
      @(negedge clk);
      chk(fifo_empty == 1'b0, "R3 visible after n+3", int'(fifo_empty), 0);
      take_direct("R2");
    end
    chk(fifo_empty == 1'b1, "R7 empty after read", int'(fifo_empty), 1);

    // R6: clear then hit straight away -> stamp 2
    pulse_clear();
    fire_hit(2, 3);
    chk(exp_q.size() == 1 && exp_q[0] == 2, "R6 predicted stamp", exp_q[0], 2);
    take_direct("R6");

    // R5: wrap past 255
    repeat (300) @(negedge clk);
    fire_hit(2, 3);
    take_direct("R5");

    // R9: reads on an empty FIFO are ignored
    rd_force = 1'b1;
    repeat (3) @(negedge clk);
    rd_force = 1'b0;
    chk(fifo_empty == 1'b1, "R9 still empty", int'(fifo_empty), 1);
    fire_hit(2, 3);
    fire_hit(2, 3);
    take_direct("R9");
    take_direct("R9");
    chk(fifo_empty == 1'b1, "R9 drained", int'(fifo_empty), 1);

    // R4: long level gives one record
    hit_async = 1'b0;
    fire_hit(20, 4);
    take_direct("R4");
    chk(fifo_empty == 1'b1, "R4 single record", int'(fifo_empty), 1);

    // Scoreboard run with varied spacing
    held = 0;
    drain = 1'b1;
    for (int i = 0; i < 12; i++) fire_hit(2 + (i % 3), 2 + (i % 4));
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all records seen", exp_q.size(), 0);

    // R10: reads and writes on shared edges
    drain = 1'b0;
    held = 0;
    for (int i = 0; i < 3; i++) fire_hit(2, 2);
    drain = 1'b1;
    for (int i = 0; i < 3; i++) fire_hit(2, 2);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R10 no record lost", exp_q.size(), 0);
    chk(fifo_empty == 1'b1, "R10 empty at end", int'(fifo_empty), 1);

    // R8: overflow, drop and sticky flag
    drain = 1'b0;
    held = 0;
    for (int i = 0; i < DEPTH + 2; i++) fire_hit(2, 3);
    repeat (3) @(negedge clk);
    chk(overflow == 1'b1, "R8 overflow set", int'(overflow), 1);
    drain = 1'b1;
    repeat (DEPTH + 6) @(negedge clk);
    chk(exp_q.size() == 0, "R8 only DEPTH records kept", exp_q.size(), 0);
    chk(fifo_empty == 1'b1, "R8 drained", int'(fifo_empty), 1);
    chk(overflow == 1'b1, "R8 overflow sticky", int'(overflow), 1);
    pulse_clear();
    chk(overflow == 1'b0, "R8 cleared by clear pulse", int'(overflow), 0);
    fire_hit(2, 4);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R2 after clear", exp_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule